// File: doc/BRIEF.md
# Reset Classification and Access Gating Controller

This block sits between the active-low external reset pin of a memory-and-logic device and that device's internal state. It tells a cold (power-on) reset apart from a warm reset. Each class has its own minimum low-pulse width, counted in clock cycles derived from the clock frequency parameter. When a qualified pulse is released, the block raises one-cycle clear strobes. The register classes a strobe reaches depend on the reset class. The block then holds memory access off for a fixed recovery window.

A sticky "powered" flag records that one valid power-on reset has happened. From that point a pulse is judged as a warm reset. The flag drops only when the power-good input falls. While power-good is low, low time on the pin is not counted, so power-on qualification starts once the supply is steady. A reset held long enough while a flash program or erase is running raises an abort request. Flash write starts are gated off while supply lockout is asserted. Reset pulses shorter than the applicable minimum are ignored and raise no strobe. The pin is assumed to be already synchronous to `clk`.

Top module: `rst_class_gate`

## Requirements
- R1: With the powered flag clear and `pwr_good` high, a release following at least POR_CYC (= CLK_KHZ, i.e. 1 ms) consecutive low samples of `ext_rst_n` is a power-on reset. On the clock edge that first samples the pin high, `clr_pm`, `clr_mcell`, `clr_gen` and `vm_init` each rise for one cycle, and the powered flag sets.
- R2: With the powered flag set, a release following at least WARM_CYC (= ceil(150 ns in cycles)) low samples is a warm reset. It pulses only `clr_gen` and `vm_init`.
- R3: `clr_pm` and `clr_mcell` (power-management and macrocell clears) never pulse on a warm reset. They pulse only on the reset that sets the powered flag.
- R4: Every clear strobe lasts exactly one clock cycle per accepted reset.
- R5: A low pulse shorter than the minimum for the current class is ignored. It raises no strobe, leaves the powered flag unchanged and starts no recovery window.
- R6: After an accepted reset, `access_ready` stays low for REC_CYC (= ceil(120 ns in cycles)) cycles after the strobe cycle and then rises. `access_ready` is low whenever the pin was sampled low or the powered flag is clear.
- R7: `abort_req` is high on the cycle after an edge at which the pin has been low for at least WARM_CYC consecutive samples while `flash_busy` is high. It falls on the cycle after the pin is sampled high or `flash_busy` is sampled low.
- R8: `wr_go` = `wr_req` AND NOT `lockout` AND `access_ready`. It is combinational, so no write starts during lockout.
- R9: While `pwr_good` is low, the next edge clears the powered flag, the low-time counter, the recovery window and all registered outputs. A warm-length pulse after power returns is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous to clk |
| pwr_good | input | 1 | Supply established; low clears the powered flag |
| lockout | input | 1 | Supply below write-lockout threshold |
| flash_busy | input | 1 | Flash program or erase in progress |
| wr_req | input | 1 | Request to start a flash write cycle |
| clr_pm | output | 1 | Clear strobe for power-management registers (power-on only) |
| clr_gen | output | 1 | Clear strobe for general registers (both classes) |
| clr_mcell | output | 1 | Clear strobe for macrocell flip-flops (power-on only) |
| vm_init | output | 1 | Load mapping register default with security and peripheral bits zero (both classes) |
| access_ready | output | 1 | Memory access permitted |
| abort_req | output | 1 | Request to end the running program or erase cycle |
| wr_go | output | 1 | Flash write start permitted |

## Verification
The embedded assertions check the invariants between the pieces on every cycle. A power-management clear only happens when the powered flag was clear and always arms it. A general-only clear needs a prior powered flag. Strobes are never two cycles long. Readiness is low in the cycle after any accepted reset, during an abort, and whenever the block is unpowered. Only the bench's scenarios can show the exact pulse-width boundaries (POR_CYC-1 against POR_CYC, WARM_CYC-1 against WARM_CYC), the length of the recovery window, the abort onset cycle, and the fact that a power-good drop turns a warm-length pulse into an ignored one. The bench checks these against a behavioural model on every clock and against scenario strobe counts.

// File: rtl/rst_class_pkg.sv
package rst_class_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_COLD = 2'd1,
        RK_WARM = 2'd2
    } rst_kind_e;

    // Round a duration in ns up to whole clock cycles at a clock of khz kHz.
    function automatic int ns_to_cyc(input int khz, input int ns);
        return (khz * ns + 999999) / 1000000;
    endfunction

endpackage

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual
    import rst_class_pkg::*;
#(
    parameter int COLD_CYC = 100000,
    parameter int WARM_CYC = 15,
    parameter int CW       = $clog2(COLD_CYC + 1)
) (
    input  logic      clk,
    input  logic      pwr_good,
    input  logic      pin_n,
    output rst_kind_e kind,
    output logic      powered,
    output logic      powered_nx,
    output logic      low_armed
);

    typedef struct packed {
        logic          pin;
        logic [CW-1:0] cnt;
        logic          powered;
    } qual_t;

    qual_t q_q, q_d;

    always_comb begin
        q_d     = q_q;
        q_d.pin = pin_n;
        kind    = RK_NONE;
        if (!pwr_good) begin
            q_d.cnt     = '0;
            q_d.powered = 1'b0;
        end else begin
            if (pin_n) begin
                q_d.cnt = '0;
                if (!q_q.pin) begin
                    if (!q_q.powered && (q_q.cnt >= CW'(COLD_CYC)))
                        kind = RK_COLD;
                    else if (q_q.powered && (q_q.cnt >= CW'(WARM_CYC)))
                        kind = RK_WARM;
                end
            end else if (q_q.cnt < CW'(COLD_CYC)) begin
                q_d.cnt = q_q.cnt + CW'(1);
            end
            if (kind == RK_COLD)
                q_d.powered = 1'b1;
        end
        low_armed  = pwr_good && !pin_n && (q_d.cnt >= CW'(WARM_CYC));
        powered_nx = q_d.powered;
        powered    = q_q.powered;
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

endmodule

// File: rtl/rst_recovery.sv
module rst_recovery #(
    parameter int REC_CYC = 12,
    parameter int RW      = $clog2(REC_CYC + 2)
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic start,
    input  logic powered_nx,
    input  logic pin_n,
    output logic ready
);

    typedef struct packed {
        logic [RW-1:0] rec;
        logic          rdy;
    } rec_t;

    rec_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!pwr_good)
            r_d.rec = '0;
        else if (start)
            r_d.rec = RW'(REC_CYC);
        else if (r_q.rec != '0)
            r_d.rec = r_q.rec - RW'(1);
        r_d.rdy = pwr_good && powered_nx && pin_n && (r_d.rec == '0);
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign ready = r_q.rdy;

    // R6
    rec_window_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        ((REC_CYC > 0) && start) |=> !ready);

endmodule

// File: rtl/rst_class_gate.sv
module rst_class_gate
    import rst_class_pkg::*;
#(
    parameter int CLK_KHZ = 100000
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic pwr_good,
    input  logic lockout,
    input  logic flash_busy,
    input  logic wr_req,
    output logic clr_pm,
    output logic clr_gen,
    output logic clr_mcell,
    output logic vm_init,
    output logic access_ready,
    output logic abort_req,
    output logic wr_go
);

    localparam int COLD_CYC = CLK_KHZ;               // 1 ms
    localparam int WARM_CYC = ns_to_cyc(CLK_KHZ, 150);
    localparam int REC_CYC  = ns_to_cyc(CLK_KHZ, 120);

    typedef struct packed {
        logic pm;
        logic gen;
        logic mc;
        logic vm;
        logic abort;
    } out_t;

    rst_kind_e kind;
    logic      powered, powered_nx, low_armed, ready;
    out_t      o_q, o_d;

    rst_pulse_qual #(
        .COLD_CYC (COLD_CYC),
        .WARM_CYC (WARM_CYC)
    ) u_qual (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .pin_n      (ext_rst_n),
        .kind       (kind),
        .powered    (powered),
        .powered_nx (powered_nx),
        .low_armed  (low_armed)
    );

    rst_recovery #(
        .REC_CYC (REC_CYC)
    ) u_rec (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .start      (kind != RK_NONE),
        .powered_nx (powered_nx),
        .pin_n      (ext_rst_n),
        .ready      (ready)
    );

    always_comb begin
        o_d       = '0;
        o_d.pm    = (kind == RK_COLD);
        o_d.mc    = (kind == RK_COLD);
        o_d.gen   = (kind != RK_NONE);
        o_d.vm    = (kind != RK_NONE);
        o_d.abort = low_armed && flash_busy;
    end

    always_ff @(posedge clk) begin
        o_q <= o_d;
    end

    assign clr_pm       = o_q.pm;
    assign clr_gen      = o_q.gen;
    assign clr_mcell    = o_q.mc;
    assign vm_init      = o_q.vm;
    assign abort_req    = o_q.abort;
    assign access_ready = ready;
    assign wr_go        = wr_req && !lockout && ready;

    // R1
    cold_arms_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        clr_pm |-> powered);

    // R3
    cold_once_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (clr_pm || clr_mcell) |-> !$past(powered));

    // R2
    warm_needs_power_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (clr_gen && !clr_pm) |-> $past(powered));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        clr_gen |=> !clr_gen);

    // R7
    abort_blocks_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        abort_req |-> !access_ready);

    // R9
    unpowered_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !powered |-> !access_ready);

endmodule

// File: tb/sim_rst_class_gate.sv
module sim_rst_class_gate;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ  = 40000;
    localparam int POR  = KHZ;
    localparam int WARM = (KHZ * 150 + 999999) / 1000000;
    localparam int REC  = (KHZ * 120 + 999999) / 1000000;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0, pwr_good = 1'b0, lockout = 1'b1;
    logic flash_busy = 1'b0, wr_req = 1'b0;
    logic clr_pm, clr_gen, clr_mcell, vm_init, access_ready, abort_req, wr_go;

    int checks = 0, errors = 0;
    int n_pm = 0, n_gen = 0, n_mc = 0, n_vm = 0;
    bit done = 1'b0, started = 1'b0;

    // behavioural reference state
    int lc = 0, rec = 0;
    bit pw = 0, pinq = 1, rise, por, warm;
    bit e_pm = 0, e_gen = 0, e_mc = 0, e_vm = 0, e_rdy = 0, e_ab = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_class_gate #(.CLK_KHZ(KHZ)) u0 (
        .clk(clk), .ext_rst_n(ext_rst_n), .pwr_good(pwr_good), .lockout(lockout),
        .flash_busy(flash_busy), .wr_req(wr_req), .clr_pm(clr_pm), .clr_gen(clr_gen),
        .clr_mcell(clr_mcell), .vm_init(vm_init), .access_ready(access_ready),
        .abort_req(abort_req), .wr_go(wr_go)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!pwr_good) begin
            lc = 0; pw = 0; rec = 0;
            e_pm = 0; e_gen = 0; e_mc = 0; e_vm = 0; e_rdy = 0; e_ab = 0;
        end else begin
            rise = !pinq && ext_rst_n;
            por  = rise && !pw && (lc >= POR);
            warm = rise && pw && (lc >= WARM);
            if (ext_rst_n) lc = 0;
            else if (lc < POR) lc = lc + 1;
            if (por) pw = 1;
            if (por || warm) rec = REC;
            else if (rec > 0) rec = rec - 1;
            e_pm = por; e_mc = por; e_gen = por || warm; e_vm = por || warm;
            e_rdy = pw && ext_rst_n && (rec == 0);
            e_ab  = !ext_rst_n && (lc >= WARM) && flash_busy;
        end
        pinq = ext_rst_n;
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk(clr_pm === e_pm, "R3 clr_pm", clr_pm, e_pm);
            chk(clr_gen === e_gen, "R2 clr_gen", clr_gen, e_gen);
            chk(clr_mcell === e_mc, "R1 clr_mcell", clr_mcell, e_mc);
            chk(vm_init === e_vm, "R4 vm_init", vm_init, e_vm);
            chk(access_ready === e_rdy, "R6 access_ready", access_ready, e_rdy);
            chk(abort_req === e_ab, "R7 abort_req", abort_req, e_ab);
            chk(wr_go === (wr_req && !lockout && e_rdy), "R8 wr_go", wr_go,
                wr_req && !lockout && e_rdy);
            if (clr_pm === 1'b1) n_pm++;
            if (clr_gen === 1'b1) n_gen++;
            if (clr_mcell === 1'b1) n_mc++;
            if (vm_init === 1'b1) n_vm++;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse(input int n);
        ext_rst_n = 1'b0;
        step(n);
        ext_rst_n = 1'b1;
        step(REC + 5);
    endtask

    initial begin
        step(5);
        // reset state, R9
        chk(access_ready === 1'b0 && clr_gen === 1'b0, "R9 reset state", access_ready, 0);

        // one cycle short of the cold minimum: ignored (R5, R1)
        pwr_good = 1'b1;
        step(POR - 1);
        ext_rst_n = 1'b1;
        step(REC + 5);
        chk(n_pm == 0, "R5 short cold ignored", n_pm, 0);
        chk(access_ready === 1'b0, "R1 not powered yet", access_ready, 0);

        // exact cold minimum (R1, R6)
        ext_rst_n = 1'b0;
        step(POR);
        ext_rst_n = 1'b1;
        step(1);
        chk(clr_pm === 1'b1 && clr_mcell === 1'b1, "R1 cold strobes", clr_pm, 1);
        chk(access_ready === 1'b0, "R6 window start", access_ready, 0);
        step(REC - 1);
        chk(access_ready === 1'b0, "R6 window end-1", access_ready, 0);
        step(1);
        chk(access_ready === 1'b1, "R6 ready after window", access_ready, 1);
        chk(n_pm == 1 && n_mc == 1 && n_gen == 1 && n_vm == 1, "R4 single cold strobe", n_gen, 1);

        // write gating (R8)
        wr_req = 1'b1;
        step(1);
        chk(wr_go === 1'b0, "R8 lockout blocks", wr_go, 0);
        lockout = 1'b0;
        #1;
        chk(wr_go === 1'b1, "R8 write allowed", wr_go, 1);
        step(2);
        lockout = 1'b1;
        step(1);

        // warm boundary (R5, R2, R3)
        pulse(WARM - 1);
        chk(n_gen == 1, "R5 short warm ignored", n_gen, 1);
        pulse(WARM);
        chk(n_gen == 2 && n_vm == 2, "R2 warm strobes", n_gen, 2);
        chk(n_pm == 1 && n_mc == 1, "R3 warm leaves pm", n_pm, 1);

        // abort during flash busy (R7)
        flash_busy = 1'b1;
        ext_rst_n  = 1'b0;
        step(WARM - 1);
        chk(abort_req === 1'b0, "R7 abort not yet", abort_req, 0);
        step(1);
        chk(abort_req === 1'b1, "R7 abort raised", abort_req, 1);
        flash_busy = 1'b0;
        step(1);
        chk(abort_req === 1'b0, "R7 abort drops with busy", abort_req, 0);
        ext_rst_n = 1'b1;
        step(REC + 5);
        chk(n_gen == 3, "R2 second warm", n_gen, 3);

        // power loss clears the powered flag (R9)
        pwr_good = 1'b0;
        step(3);
        chk(access_ready === 1'b0, "R9 unpowered", access_ready, 0);
        pwr_good = 1'b1;
        pulse(WARM + 2);
        chk(n_gen == 3 && access_ready === 1'b0, "R9 warm pulse ignored after loss", n_gen, 3);
        pulse(POR);
        chk(n_pm == 2 && access_ready === 1'b1, "R1 cold again", n_pm, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule